// File: doc/BRIEF.md
# Two-Digit Multiplexed Decimal Display Driver

This block shows a binary number from 0 to 99 as two decimal digits on a pair of common-anode seven-segment displays that share a single set of segment lines. It clamps the incoming value, splits it into a tens and a ones digit, and turns each digit into an active-low segment pattern. A time-multiplexing scanner then lights one digit at a time, putting the matching pattern on the shared segment bus.

Each digit stays lit for a fixed dwell period. The default dwell is 500,000 cycles, which is 10 ms at 50 MHz, so the pair refreshes at 50 Hz. The select lines and the segment bus are both registered and change on the same clock edge. Because of this, a pattern never shows on the wrong digit. The input value is sampled only on the edge that opens a slot, so a digit keeps the same pattern for the whole of its dwell. The external transistor stages invert the select drive, so a select line is driven low to light its digit.

Top module: `dec2_scan_display`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the next outputs are all off: `dig_sel_n` = 2'b11 and `seg_n` = 8'hFF.
- R2: The first rising edge with `rst_n` high opens slot 0. During slot 0, `dig_sel_n` = 2'b10 (bit 0, digit 0, driven low) and `seg_n` carries the tens digit.
- R3: Each slot lasts exactly DWELL clock cycles and slots alternate 0,1,0,1. During slot 1, `dig_sel_n` = 2'b01 (bit 1, digit 1, driven low) and `seg_n` carries the ones digit.
- R4: Once out of reset, exactly one select line is low at any time.
- R5: Segment patterns are active-low in bit order {h,g,f,e,d,c,b,a}, and h is always 1. The patterns for digits 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90 (hex).
- R6: For an input v from 0 to 99, the tens digit is v/10 and the ones digit is v%10. A tens digit of zero is shown as "0".
- R7: Any input above 99 is shown as 99.
- R8: The value is sampled only on the edge that opens a slot. Changes to `value_in` in the middle of a slot have no effect on the outputs until the next slot opens.
- R9: `dig_sel_n` and `seg_n` change only on the edge that opens a slot, and both change on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| value_in | input | 7 | Binary value to display (clamped to 99) |
| dig_sel_n | output | 2 | Digit selects, active low; bit 0 = tens digit, bit 1 = ones digit |
| seg_n | output | 8 | Shared segment bus, active low, {h,g,f,e,d,c,b,a} |

## Verification
The assertions assume that `rst_n` is synchronous to `clk`. They also assume that `value_in` is a settled 7-bit value at each slot-opening edge. They do not assume that `value_in` is at most 99, because the clamp is checked directly. The stimulus changes `value_in` only on falling edges. It deliberately changes the value in the middle of slots and drives values from 100 to 127, so the sampling and clamping rules are exercised within those assumptions. A reduced dwell keeps many slot changes within a short run.

// File: rtl/disp_pkg.sv
// Package: shared types and constants for the two-digit scanned display.
// Assumes two digits, common anode, active-low segment and select drive.
package disp_pkg;
    localparam int DIGITS    = 2;
    localparam int SEG_W     = 8;
    localparam int BCD_W     = 4;
    localparam int MAX_SHOWN = 99;
    localparam int RADIX     = 10;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [DIGITS-1:0] sel_t;

    localparam seg_t SEG_BLANK = '1;
    localparam sel_t SEL_NONE  = '1;
endpackage

// File: rtl/dec_splitter.sv
// Module: clamps a binary value to MAX_SHOWN and splits it into tens and ones.
// Assumes MAX_SHOWN < 100 so two decimal digits are always enough.
module dec_splitter
    import disp_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic [VAL_W-1:0] value_in,
    output bcd_t             tens,
    output bcd_t             ones
);
    localparam logic [VAL_W-1:0] LIMIT = VAL_W'(MAX_SHOWN);
    localparam logic [VAL_W-1:0] BASE  = VAL_W'(RADIX);

    logic [VAL_W-1:0] clamped;

    // Purpose: saturate out-of-range inputs, then divide by ten.
    always_comb begin
        clamped = (value_in > LIMIT) ? LIMIT : value_in;
        tens    = BCD_W'(clamped / BASE);
        ones    = BCD_W'(clamped % BASE);
    end

    // Purpose: check the digit split against the input it came from.
    always_comb begin
        if (value_in <= LIMIT) begin
            AST_DIGITS_DECIMAL: assert ((tens <= 4'd9) && (ones <= 4'd9) &&
                (int'(tens) * 10 + int'(ones) == int'(value_in))); // R6
        end else begin
            AST_CLAMP_TOP: assert ((tens == 4'd9) && (ones == 4'd9)); // R7
        end
    end
endmodule

// File: rtl/seg_encoder.sv
// Module: maps one decimal digit to an active-low {h,g,f,e,d,c,b,a} pattern.
// Assumes digit 0..9; any other code blanks the digit. Decimal point stays dark.
module seg_encoder
    import disp_pkg::*;
(
    input  bcd_t digit,
    output seg_t pattern
);
    logic [6:0] lit;   // active-high {g,f,e,d,c,b,a}

    // Purpose: select which segments form each numeral.
    always_comb begin
        case (digit)
            4'd0:    lit = 7'b0111111;
            4'd1:    lit = 7'b0000110;
            4'd2:    lit = 7'b1011011;
            4'd3:    lit = 7'b1001111;
            4'd4:    lit = 7'b1100110;
            4'd5:    lit = 7'b1101101;
            4'd6:    lit = 7'b1111101;
            4'd7:    lit = 7'b0000111;
            4'd8:    lit = 7'b1111111;
            4'd9:    lit = 7'b1101111;
            default: lit = 7'b0000000;
        endcase
    end

    // Purpose: invert for common-anode drive with the point held off.
    assign pattern = {1'b1, ~lit};
endmodule

// File: rtl/dwell_timer.sv
// Module: slot timer; opens slot 0 after reset, then a new slot every DWELL cycles.
// Assumes DWELL >= 1 and a synchronous active-low reset.
module dwell_timer #(
    parameter int DWELL = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic load,
    output logic next_slot
);
    localparam int CNT_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt;
    logic             live;
    logic             slot;

    // Purpose: a slot opens at the first edge out of reset and at each dwell end.
    assign load      = !live || (cnt == LAST);
    assign next_slot = live ? ~slot : 1'b0;

    // Purpose: count within a slot and track which slot is showing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            live <= 1'b0;
            slot <= 1'b0;
        end else if (load) begin
            cnt  <= '0;
            live <= 1'b1;
            slot <= next_slot;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_DWELL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R3
endmodule

// File: rtl/dec2_scan_display.sv
// Module: two-digit scanned decimal display driver (top).
// Assumes common-anode digits behind inverting select stages; all outputs
// active low. Value is sampled only on the edge that opens each slot.
module dec2_scan_display
    import disp_pkg::*;
#(
    parameter int VAL_W = 7,
    parameter int DWELL = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] value_in,
    output logic [1:0]       dig_sel_n,
    output logic [7:0]       seg_n
);
    bcd_t digit [DIGITS];
    seg_t pat   [DIGITS];
    logic load;
    logic next_slot;

    dec_splitter #(.VAL_W(VAL_W)) u_split (
        .value_in (value_in),
        .tens     (digit[0]),
        .ones     (digit[1])
    );

    // Purpose: one encoder per digit position.
    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_enc
        seg_encoder u_enc (
            .digit   (digit[gi]),
            .pattern (pat[gi])
        );
    end

    dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .next_slot (next_slot)
    );

    // Purpose: update select and segment bus together at each slot opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_sel_n <= SEL_NONE;
            seg_n     <= SEG_BLANK;
        end else if (load) begin
            dig_sel_n <= ~(sel_t'(1) << next_slot);
            seg_n     <= pat[next_slot];
        end
    end

    AST_RESET_BLANK: assert property (@(posedge clk)
        !rst_n |=> (dig_sel_n == 2'b11) && (seg_n == 8'hFF)); // R1
    AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_sel_n != 2'b11) |-> ($countones(dig_sel_n) == 1)); // R4
    AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dig_sel_n != 2'b11) |=> (dig_sel_n == ~$past(dig_sel_n))); // R3
    AST_HOLD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dig_sel_n) && $stable(seg_n)); // R9
endmodule

// File: tb/sim_dec2_scan_display.sv
module sim_dec2_scan_display;
    localparam int DW = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] value_in = '0;
    logic [1:0] dig_sel_n;
    logic [7:0] seg_n;

    int checks = 0;
    int errors = 0;
    int slot = 0;

    always #2 clk = ~clk;

    dec2_scan_display #(.VAL_W(7), .DWELL(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .value_in(value_in),
        .dig_sel_n(dig_sel_n), .seg_n(seg_n)
    );

    function automatic logic [7:0] enc(input int d);
        case (d)
            0: return 8'hC0; 1: return 8'hF9; 2: return 8'hA4; 3: return 8'hB0;
            4: return 8'h99; 5: return 8'h92; 6: return 8'h82; 7: return 8'hF8;
            8: return 8'h80; default: return 8'h90;
        endcase
    endfunction

    function automatic logic [7:0] exp_seg(input int v, input int s);
        int c;
        c = (v > 99) ? 99 : v;
        return (s == 0) ? enc(c / 10) : enc(c % 10);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One slot: entered at a negedge just before the slot-opening edge.
    task automatic do_slot(input int v, input string req);
        logic [1:0] es;
        logic [7:0] eg;
        value_in = 7'(v);
        @(posedge clk); @(negedge clk);
        es = (slot == 0) ? 2'b10 : 2'b01;
        eg = exp_seg(v, slot);
        chk({req, " R2 R3 sel"}, {6'd0, dig_sel_n}, {6'd0, es});
        chk({req, " R5 R6 seg"}, seg_n, eg);
        for (int k = 1; k < DW; k++) begin
            if (k == 2) value_in = 7'($urandom);   // mid-slot change, R8
            @(posedge clk); @(negedge clk);
        end
        chk({req, " R8 R9 sel hold"}, {6'd0, dig_sel_n}, {6'd0, es});
        chk({req, " R8 R9 seg hold"}, seg_n, eg);
        slot = 1 - slot;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3: watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        int dir [10] = '{0, 7, 42, 99, 100, 127, 9, 90, 10, 55};
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 sel in reset", {6'd0, dig_sel_n}, 8'h03);
        chk("R1 seg in reset", seg_n, 8'hFF);
        rst_n = 1'b1;
        slot = 0;
        foreach (dir[i]) begin
            do_slot(dir[i], "R6 R7 directed");
            do_slot(dir[i], "R6 R7 directed");
        end
        // reset in the middle of slot 1
        do_slot(34, "R3");
        value_in = 7'd61;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 sel after mid reset", {6'd0, dig_sel_n}, 8'h03);
        chk("R1 seg after mid reset", seg_n, 8'hFF);
        rst_n = 1'b1;
        slot = 0;
        do_slot(61, "R2 after reset");
        for (int n = 0; n < 60; n++) begin
            do_slot(int'($urandom % 128), "R7 random");
        end
        finish_run();
    end
endmodule